// File: doc/BRIEF.md
# Input Activity Monitor with Interrupt

This block watches a set of single-bit inputs for signs of life. Between two samples, a counter for each input records whether the input has toggled. An input is reported as live only when it has changed level at least twice. A slow, free-running monitor strobe arrives on its own pin. On each rising edge of that strobe, every counter's verdict is copied into a status bit and the counter starts again from zero. The inputs and the strobe are synchronised to the system clock, and all edges are detected on that clock.

The status bits are grouped four to a read-only register. A host reads them through a small port with a chip select, a read strobe and an address. A sample can alter the contents of one or more registers. When it does, each altered register raises its own pending flag, and an active-low interrupt line goes low. Reading a register clears its flag without touching its contents. The line therefore returns high only after every register that changed has been read.

Top module: `act_monitor`

## Requirements
- R1: An input's status bit reads 0 (active) only if its synchronised level changed at least twice during the sample period. With zero changes or one change, the bit reads 1.
- R2: Status bits change only on a rising edge of the monitor strobe. Each such edge restarts every input's transition count from zero.
- R3: After reset, every status bit is 1, no flag is pending and `irq_n` is high.
- R4: The register at address 0x21+k holds inputs 4k to 4k+3, with input 4k+b in data bit b, for k = 0..3. Address 0x25 holds input 16 in bit 0, and its bits 3..1 read 0. Any other address reads 0.
- R5: When a sample alters the contents of any status register, `irq_n` goes low.
- R6: A sample that alters no register leaves `irq_n` high.
- R7: A read of a register clears that register's pending flag. Its contents stay the same, and reading it again returns the same value.
- R8: `irq_n` stays low until every register altered by a sample has been read.
- R9: Suppose a sample alters a register in the same cycle that a read of that register takes effect. The flag stays set and `irq_n` stays low.
- R10: `rdata` is 0 whenever `cs_n` or `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| act_in | input | 17 | Monitored inputs, asynchronous |
| mon_clk_in | input | 1 | Slow monitor strobe, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 6 | Register address |
| rdata | output | 4 | Read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A table of stimulus vectors drives three kinds of input in each period: inputs toggled twice, inputs toggled once and inputs left idle. This separates the two-transition threshold from a single glitch. Consecutive vectors are built either to alter several registers or to repeat the previous result exactly, which separates a change-triggered interrupt from one driven by level. Directed cases cover three situations. In the first, reads are issued before the strobe edge, to show that the status waits for the strobe. In the second, a sample alters two registers and they are read one at a time, to show that the interrupt persists until the last one is read. In the third, a sample and a read of the same register fall in the same cycle.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
    localparam int AM_N_IN   = 17;
    localparam int AM_GRP_W  = 4;
    localparam int AM_ADDR_W = 6;
    localparam int AM_SYNC   = 2;
    localparam int AM_N_GRP  = (AM_N_IN + AM_GRP_W - 1) / AM_GRP_W;
    localparam int AM_GIDX_W = (AM_N_GRP > 1) ? $clog2(AM_N_GRP) : 1;
    localparam logic [AM_ADDR_W-1:0] AM_BASE = 6'h21;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ONE  = 2'd1,
        ACT_TWO  = 2'd2
    } act_cnt_e;

    typedef struct packed {
        logic                 hit;
        logic [AM_GIDX_W-1:0] grp;
    } rd_sel_t;

    function automatic act_cnt_e cnt_step(act_cnt_e c, logic edge_seen);
        if (!edge_seen)      return c;
        else if (c == ACT_NONE) return ACT_ONE;
        else                 return ACT_TWO;
    endfunction
endpackage

// File: rtl/act_sync.sv
module act_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/act_detect.sv
module act_detect
    import act_mon_pkg::*;
#(
    parameter int N = AM_N_IN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic         sample,
    output logic [N-1:0] quiet
);
    logic [N-1:0] lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= '0;
        else     lvl_prev <= lvl;
    end

    for (genvar g = 0; g < N; g++) begin : g_chan
        act_cnt_e cnt;
        act_cnt_e cnt_nxt;
        assign cnt_nxt  = cnt_step(cnt, lvl[g] ^ lvl_prev[g]);
        assign quiet[g] = (cnt_nxt != ACT_TWO);
        always_ff @(posedge clk) begin
            if (rst || sample) cnt <= ACT_NONE;
            else               cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/act_status.sv
module act_status
    import act_mon_pkg::*;
#(
    parameter int                 N    = AM_N_IN,
    parameter int                 GW   = AM_GRP_W,
    parameter int                 NG   = AM_N_GRP,
    parameter int                 AW   = AM_ADDR_W,
    parameter logic [AW-1:0]      BASE = AM_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic [N-1:0]  quiet,
    input  logic          rd_act,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  status,
    output logic [NG-1:0] pend,
    output logic          strike,
    output rd_sel_t       sel,
    output logic [GW-1:0] rdata
);
    localparam int PADW = NG * GW;

    logic [PADW-1:0] cur_pad, new_pad;
    logic [NG-1:0]   chg;
    logic            rd_q;

    always_comb begin
        cur_pad = '0;
        new_pad = '0;
        cur_pad[N-1:0] = status;
        new_pad[N-1:0] = quiet;
    end

    always_comb begin
        sel = '0;
        for (int g = 0; g < NG; g++) begin
            if (addr == BASE + AW'(g)) begin
                sel.hit = 1'b1;
                sel.grp = AM_GIDX_W'(g);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_act;
    end
    assign strike = rd_act & ~rd_q;

    always_ff @(posedge clk) begin
        if (rst)         status <= '1;
        else if (sample) status <= quiet;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign chg[g] = sample && (new_pad[g*GW +: GW] != cur_pad[g*GW +: GW]);
        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else if (chg[g])
                pend[g] <= 1'b1;
            else if (strike && sel.hit && sel.grp == AM_GIDX_W'(g))
                pend[g] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NG; g++) begin
            if (rd_act && sel.hit && sel.grp == AM_GIDX_W'(g))
                rdata = cur_pad[g*GW +: GW];
        end
    end
endmodule

// File: rtl/act_monitor.sv
module act_monitor
    import act_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AM_N_IN-1:0]   act_in,
    input  logic                 mon_clk_in,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic [AM_ADDR_W-1:0] addr,
    output logic [AM_GRP_W-1:0]  rdata,
    output logic                 irq_n
);
    logic [AM_N_IN-1:0]  lvl_s;
    logic [AM_N_IN-1:0]  quiet;
    logic [AM_N_IN-1:0]  status;
    logic [AM_N_GRP-1:0] pend;
    logic                mon_s, mon_prev, mon_tick;
    logic                rd_strike;
    rd_sel_t             rd_sel;

    act_sync #(.W(AM_N_IN), .STAGES(AM_SYNC)) u_sync_in (
        .clk(clk), .rst(rst), .d(act_in), .q(lvl_s)
    );

    act_sync #(.W(1), .STAGES(AM_SYNC)) u_sync_mon (
        .clk(clk), .rst(rst), .d(mon_clk_in), .q(mon_s)
    );

    always_ff @(posedge clk) begin
        if (rst) mon_prev <= 1'b0;
        else     mon_prev <= mon_s;
    end
    assign mon_tick = mon_s & ~mon_prev;

    act_detect #(.N(AM_N_IN)) u_detect (
        .clk(clk), .rst(rst), .lvl(lvl_s), .sample(mon_tick), .quiet(quiet)
    );

    act_status u_status (
        .clk(clk), .rst(rst), .sample(mon_tick), .quiet(quiet),
        .rd_act(~cs_n & ~rd_n), .addr(addr), .status(status), .pend(pend),
        .strike(rd_strike), .sel(rd_sel), .rdata(rdata)
    );

    assign irq_n = ~|pend;
endmodule

// File: rtl/act_monitor_chk.sv
module act_monitor_chk
    import act_mon_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                mon_tick,
    input logic                rd_strike,
    input rd_sel_t             rd_sel,
    input logic [AM_N_GRP-1:0] pend,
    input logic [AM_N_IN-1:0]  status,
    input logic                irq_n,
    input logic                cs_n,
    input logic                rd_n,
    input logic [AM_GRP_W-1:0] rdata
);
    assert_hold_status_R2: assert property (@(posedge clk) disable iff (rst)
        !mon_tick |=> $stable(status));

    assert_irq_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(mon_tick));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_strike && rd_sel.hit && !mon_tick) |=> !pend[$past(rd_sel.grp)]);

    assert_no_new_pend_R8: assert property (@(posedge clk) disable iff (rst)
        !mon_tick |=> ($countones(pend) <= $countones($past(pend))));

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rdata == '0));
endmodule

bind act_monitor act_monitor_chk u_chk (
    .clk(clk), .rst(rst), .mon_tick(mon_tick), .rd_strike(rd_strike),
    .rd_sel(rd_sel), .pend(pend), .status(status), .irq_n(irq_n),
    .cs_n(cs_n), .rd_n(rd_n), .rdata(rdata)
);

// File: tb/sim_act_monitor.sv
module sim_act_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    localparam logic [16:0] V_TWICE [NV] = '{17'h1FFFF, 17'h0000F, 17'h0000F, 17'h10020, 17'h00000};
    localparam logic [16:0] V_ONCE  [NV] = '{17'h00000, 17'h00010, 17'h00010, 17'h00001, 17'h0F0F0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] din = '0;
    logic        mon = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [3:0]  rdata;
    logic        irq_n;
    logic [16:0] exp_stat;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    act_monitor u0 (
        .clk(clk), .rst(rst), .act_in(din), .mon_clk_in(mon),
        .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .rdata(rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] grp_of(input logic [16:0] s, input int g);
        logic [19:0] p;
        p = {3'b000, s};
        return p[g*4 +: 4];
    endfunction

    task automatic rd_reg(input logic [5:0] a, output logic [3:0] v);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        v = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic activity(input logic [16:0] twice, input logic [16:0] once);
        din = din ^ (twice | once);
        repeat (4) @(negedge clk);
        din = din ^ twice;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse();
        mon = 1'b1;
        repeat (6) @(negedge clk);
        mon = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Reads groups in order; irq_n must stay low until the last altered one is read.
    task automatic read_out(input logic [16:0] prev, input string req);
        logic [4:0] left;
        logic [3:0] v;
        for (int g = 0; g < 5; g++) left[g] = (grp_of(prev, g) != grp_of(exp_stat, g));
        for (int g = 0; g < 5; g++) begin
            rd_reg(6'h21 + 6'(g), v);
            chk({req, " R4 group value"}, 32'(v), 32'(grp_of(exp_stat, g)));
            left[g] = 1'b0;
            chk({req, " R8 irq after read"}, 32'(irq_n), 32'(left == 5'd0));
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [16:0] prev;
        logic [16:0] pat;
        logic [3:0]  v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_stat = '1;

        // R3: reset state
        chk("R3 irq_n at reset", 32'(irq_n), 32'd1);
        for (int g = 0; g < 5; g++) begin
            rd_reg(6'h21 + 6'(g), v);
            chk("R3 status at reset", 32'(v), 32'(grp_of(exp_stat, g)));
        end

        // Vector table: R1 threshold, R5/R6 change-driven interrupt, R4 map
        for (int i = 0; i < NV; i++) begin
            prev = exp_stat;
            activity(V_TWICE[i], V_ONCE[i]);
            pulse();
            exp_stat = ~V_TWICE[i];
            if (exp_stat != prev) chk("R5 irq on change", 32'(irq_n), 32'd0);
            else                  chk("R6 no irq without change", 32'(irq_n), 32'd1);
            read_out(prev, "R1 vector");
        end

        // R2: activity without a strobe edge leaves status alone
        prev = exp_stat;
        activity(17'h00202, 17'h0);
        rd_reg(6'h21, v);
        chk("R2 status before strobe", 32'(v), 32'(grp_of(exp_stat, 0)));
        chk("R2 irq before strobe", 32'(irq_n), 32'd1);
        pulse();
        exp_stat = ~17'h00202;
        chk("R5 irq after strobe", 32'(irq_n), 32'd0);
        // R7/R8: two-at-a-time readout, plus a re-read
        rd_reg(6'h21, v);
        chk("R7 value on read", 32'(v), 32'(grp_of(exp_stat, 0)));
        chk("R7 irq held by other group", 32'(irq_n), 32'(grp_of(prev, 1) == grp_of(exp_stat, 1) &&
            grp_of(prev, 2) == grp_of(exp_stat, 2) && grp_of(prev, 3) == grp_of(exp_stat, 3) &&
            grp_of(prev, 4) == grp_of(exp_stat, 4)));
        rd_reg(6'h21, v);
        chk("R7 value unchanged on re-read", 32'(v), 32'(grp_of(exp_stat, 0)));
        read_out(prev, "R8 readout");

        // R10 and unmapped addresses
        @(negedge clk);
        addr = 6'h21; cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        chk("R10 rdata with rd_n high", 32'(rdata), 32'd0);
        cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R10 rdata with cs_n high", 32'(rdata), 32'd0);
        rd_n = 1'b1;
        rd_reg(6'h20, v);
        chk("R4 unmapped 0x20", 32'(v), 32'd0);
        rd_reg(6'h26, v);
        chk("R4 unmapped 0x26", 32'(v), 32'd0);

        // R9: sample and read of the same register in one cycle
        prev = exp_stat;
        pat  = (~exp_stat) ^ 17'h00001;
        activity(pat, 17'h0);
        @(negedge clk);
        mon = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 6'h21; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
        mon = 1'b0;
        repeat (6) @(negedge clk);
        exp_stat = ~pat;
        chk("R9 flag kept on coinciding read", 32'(irq_n), 32'd0);
        rd_reg(6'h21, v);
        chk("R9 value", 32'(v), 32'(grp_of(exp_stat, 0)));
        chk("R9 irq cleared by later read", 32'(irq_n), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule